// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked single-port memory with a data word split into byte lanes. On every rising clock edge it decodes three chip selects, two address strobes and an advance input. Each edge is then one of five kinds: idle, deselect, burst begin, burst continue or burst suspend. It is also either a read or a write. One strobe serves the processor side and one serves the cache controller. They differ in how the first chip select masks them and in whether a burst they open may be a write.

Bursts cover four words. The two low address bits step linearly and wrap within the aligned group of four. Byte lane write enables come from a global write input, or from a byte qualifier combined with one enable per lane. A mode input picks the read path. Flow-through gives the data combinationally in the cycle after the address edge. Pipeline adds an output register and one more cycle of latency. The output enable and a sleep input gate the output without waiting for a clock. The bidirectional bus is modelled as separate input, output and drive-enable ports. The array depth is a parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: A strobe cycle selects the block only when sel_a_ni=0, sel_b_i=1 and sel_c_ni=0. A strobe cycle under any other select combination is a deselect: it ends the burst, and the output is off after that edge.
- R2: When sel_a_ni=1, a low cpu_strobe_ni is ignored. With ctl_strobe_ni high, such a cycle is treated as a continue or a suspend. With ctl_strobe_ni low, it is a deselect.
- R3: A burst begun by cpu_strobe_ni=0 is always a read, whatever the write inputs are.
- R4: A burst begun by ctl_strobe_ni=0 while cpu_strobe_ni=1 is a write when any lane enable is active. Otherwise it is a read.
- R5: With both strobes high during an active burst, adv_ni=0 steps address bits [1:0] by one, wrapping 3 to 0 within the group of four. adv_ni=1 repeats the current address. Each such cycle reads or writes according to the lane enables of that cycle. With no active burst, both strobes high is an idle cycle and drives nothing.
- R6: all_wr_ni=0 enables every lane. Otherwise byte_qual_ni=0 enables lane n where lane_wr_ni[n]=0. Lane n covers data bits [8n+7:8n]. With byte_qual_ni=1, or with every lane_wr_ni bit high, the cycle is a read.
- R7: With pipe_mode_i=0 (flow-through), the word read on edge k appears on data_o, with data_oe_o=1, from edge k until edge k+1.
- R8: With pipe_mode_i=1 (pipeline), the word read on edge k appears from edge k+1. The output turns on two edges after a selecting read and turns off one edge after a deselect.
- R9: data_oe_o is 1 only for a read while oe_ni=0 and sleep_i=0. A change on oe_ni takes effect without a clock edge.
- R10: While sleep_i=1, nothing is written and no internal state changes, and data_oe_o=0. Once sleep_i falls, the output from before the sleep returns.
- R11: The active-low reset rst_ni clears the burst and output state at once. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_a_ni | input | 1 | Chip select A, active low, masks the processor strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| cpu_strobe_ni | input | 1 | Processor address strobe, active low |
| ctl_strobe_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| addr_i | input | AW | Word address |
| all_wr_ni | input | 1 | Global write, active low |
| byte_qual_ni | input | 1 | Byte write qualifier, active low |
| lane_wr_ni | input | LANES | Per-lane write enables, active low |
| data_i | input | DW | Write data |
| pipe_mode_i | input | 1 | 1 selects pipeline reads, 0 selects flow-through reads |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Standby, active high |
| data_o | output | DW | Read data |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
A table of flow-through cycles runs through several patterns. Controller-started writes fill a four-word group, and a byte-write continue on the wrap checks the step order. A processor-started read is given write inputs, which tells R3 apart from R4. Masked and unmasked strobes are run under each select combination. A controller begin with every lane enable high must read, which shows that an all-high byte term is not a write. Directed cycles then repeat a short read burst in pipeline mode to measure the one-cycle shift and the turn-off edge. They also toggle the output enable and sleep without a clock edge, and apply reset during a burst to show that the burst ends but the stored words remain.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             cpu_strobe_ni,
  input  logic             ctl_strobe_ni,
  input  logic             adv_ni,
  input  logic             all_wr_ni,
  input  logic             byte_qual_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic             burst_active_i,
  output cyc_e             kind_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             read_o
);
  logic [LANES-1:0] wr_term;
  logic             cpu_start, strobe, chip_sel;

  always_comb begin
    if (!all_wr_ni)         wr_term = '1;
    else if (!byte_qual_ni) wr_term = ~lane_wr_ni;
    else                    wr_term = '0;
    // processor strobe is masked by select A alone
    cpu_start = !cpu_strobe_ni && !sel_a_ni;
    strobe    = cpu_start || !ctl_strobe_ni;
    chip_sel  = !sel_a_ni && sel_b_i && !sel_c_ni;
    kind_o    = CYC_IDLE;
    lane_we_o = '0;
    read_o    = 1'b0;
    if (strobe) begin
      if (chip_sel) begin
        kind_o = CYC_BEGIN;
        if (cpu_start) begin
          read_o = 1'b1;
        end else begin
          lane_we_o = wr_term;
          read_o    = (wr_term == '0);
        end
      end else begin
        kind_o = CYC_DESEL;
      end
    end else if (burst_active_i) begin
      kind_o    = adv_ni ? CYC_SUSP : CYC_CONT;
      lane_we_o = wr_term;
      read_o    = (wr_term == '0);
    end
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  cyc_e          kind_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cyc_addr_o,
  output logic [AW-1:0] base_o,
  output logic          active_o
);
  always_comb begin
    unique case (kind_i)
      CYC_BEGIN: cyc_addr_o = addr_i;
      CYC_CONT:  cyc_addr_o = {base_o[AW-1:2], 2'(base_o[1:0] + 2'd1)};
      default:   cyc_addr_o = base_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_o   <= '0;
    end else if (!hold_i) begin
      unique case (kind_i)
        CYC_BEGIN: begin
          active_o <= 1'b1;
          base_o   <= cyc_addr_o;
        end
        CYC_CONT, CYC_SUSP: base_o <= cyc_addr_o;
        CYC_DESEL: active_o <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] lane_we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          read_cyc_i,
  input  logic [AW-1:0] cyc_addr_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          pipe_mode_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_valid_o,
  output logic          pipe_valid_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic [DW-1:0] pipe_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_addr_o    <= '0;
      pipe_valid_o <= 1'b0;
      pipe_data    <= '0;
    end else if (!hold_i) begin
      rd_valid_o   <= read_cyc_i;
      if (read_cyc_i) rd_addr_o <= cyc_addr_i;
      pipe_valid_o <= rd_valid_o;
      pipe_data    <= rdata_i;
    end
  end

  assign data_o    = pipe_mode_i ? pipe_data : rdata_i;
  assign data_oe_o = (pipe_mode_i ? pipe_valid_o : rd_valid_o) && !oe_ni && !sleep_i;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             cpu_strobe_ni,
  input  logic             ctl_strobe_ni,
  input  logic             adv_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             all_wr_ni,
  input  logic             byte_qual_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic [DW-1:0]    data_i,
  input  logic             pipe_mode_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o
);
  cyc_e             kind;
  logic [LANES-1:0] lane_we, lane_we_g;
  logic             read_cyc, burst_active, rd_valid, pipe_valid;
  logic [AW-1:0]    cyc_addr, base_addr, rd_addr;
  logic [DW-1:0]    rdata;

  sbs_decode #(.LANES(LANES)) u_decode (
    .sel_a_ni       (sel_a_ni),
    .sel_b_i        (sel_b_i),
    .sel_c_ni       (sel_c_ni),
    .cpu_strobe_ni  (cpu_strobe_ni),
    .ctl_strobe_ni  (ctl_strobe_ni),
    .adv_ni         (adv_ni),
    .all_wr_ni      (all_wr_ni),
    .byte_qual_ni   (byte_qual_ni),
    .lane_wr_ni     (lane_wr_ni),
    .burst_active_i (burst_active),
    .kind_o         (kind),
    .lane_we_o      (lane_we),
    .read_o         (read_cyc)
  );

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (sleep_i),
    .kind_i     (kind),
    .addr_i     (addr_i),
    .cyc_addr_o (cyc_addr),
    .base_o     (base_addr),
    .active_o   (burst_active)
  );

  assign lane_we_g = lane_we & {LANES{!sleep_i}};

  sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .lane_we_i (lane_we_g),
    .waddr_i   (cyc_addr),
    .wdata_i   (data_i),
    .raddr_i   (rd_addr),
    .rdata_o   (rdata)
  );

  sbs_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (sleep_i),
    .read_cyc_i   (read_cyc),
    .cyc_addr_i   (cyc_addr),
    .rdata_i      (rdata),
    .pipe_mode_i  (pipe_mode_i),
    .oe_ni        (oe_ni),
    .sleep_i      (sleep_i),
    .rd_addr_o    (rd_addr),
    .rd_valid_o   (rd_valid),
    .pipe_valid_o (pipe_valid),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             oe_ni,
  input logic             sel_a_ni,
  input logic             cpu_strobe_ni,
  input logic             data_oe_o,
  input cyc_e             kind_i,
  input logic [AW-1:0]    base_i,
  input logic             active_i,
  input logic             rd_valid_i,
  input logic             pipe_valid_i,
  input logic [LANES-1:0] lane_we_i
);
  a_r1_desel_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_DESEL && !sleep_i) |=> !active_i);

  a_r3_cpu_start_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strobe_ni && !sel_a_ni) |-> (lane_we_i == '0));

  a_r5_cont_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_CONT && !sleep_i) |=> (base_i[1:0] == 2'($past(base_i[1:0]) + 2'd1)));

  a_r8_pipe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> (pipe_valid_i == $past(rd_valid_i)));

  a_r9_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || sleep_i) |-> !data_oe_o);

  a_r10_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(base_i) && $stable(active_i) && $stable(rd_valid_i)));
endmodule

bind sync_burst_sram sbs_checker #(.AW(AW), .LANES(LANES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_i       (sleep_i),
  .oe_ni         (oe_ni),
  .sel_a_ni      (sel_a_ni),
  .cpu_strobe_ni (cpu_strobe_ni),
  .data_oe_o     (data_oe_o),
  .kind_i        (kind),
  .base_i        (base_addr),
  .active_i      (burst_active),
  .rd_valid_i    (rd_valid),
  .pipe_valid_i  (pipe_valid),
  .lane_we_i     (lane_we)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int CLK_P = 10;
  localparam int NV    = 21;
  // row: ctrl{sel_a_n,sel_b,sel_c_n,cpu_n,ctl_n,adv_n,all_wr_n,qual_n}, lane_n, addr, din, exp_oe, exp_q
  localparam logic [84:0] VEC [NV] = '{
    {8'b01010101, 4'hF, 8'h10, 32'h11111111, 1'b0, 32'h0},        // R4 ctl begin write
    {8'b01011001, 4'hF, 8'hFF, 32'h22222222, 1'b0, 32'h0},        // R5 continue write
    {8'b01011001, 4'hF, 8'hFF, 32'h33333333, 1'b0, 32'h0},        // R5
    {8'b01011001, 4'hF, 8'hFF, 32'h44444444, 1'b0, 32'h0},        // R5
    {8'b01011010, 4'b1110, 8'hFF, 32'h000000AB, 1'b0, 32'h0},     // R6 lane0 on wrap
    {8'b01011110, 4'b0111, 8'hFF, 32'hCD000000, 1'b0, 32'h0},     // R6 lane3 suspend
    {8'b01001101, 4'hF, 8'h12, 32'hFFFFFFFF, 1'b1, 32'h33333333}, // R3 cpu begin with write set
    {8'b01011011, 4'hF, 8'hFF, 32'h0, 1'b1, 32'h44444444},        // R5
    {8'b01011011, 4'hF, 8'hFF, 32'h0, 1'b1, 32'hCD1111AB},        // R5 wrap
    {8'b01011111, 4'hF, 8'hFF, 32'h0, 1'b1, 32'hCD1111AB},        // R5 suspend
    {8'b01010111, 4'hF, 8'h11, 32'h0, 1'b1, 32'h22222222},        // R4 ctl begin read
    {8'b11001011, 4'hF, 8'hFF, 32'h0, 1'b1, 32'h33333333},        // R2 masked cpu strobe
    {8'b11010111, 4'hF, 8'h10, 32'h0, 1'b0, 32'h0},               // R2 deselect
    {8'b01011011, 4'hF, 8'hFF, 32'h0, 1'b0, 32'h0},               // R5 idle
    {8'b01010111, 4'hF, 8'h10, 32'h0, 1'b1, 32'hCD1111AB},        // R7 flow read
    {8'b00010111, 4'hF, 8'h10, 32'h0, 1'b0, 32'h0},               // R1 sel_b low
    {8'b01010111, 4'hF, 8'h12, 32'h0, 1'b1, 32'h33333333},        // R7
    {8'b01101111, 4'hF, 8'h12, 32'h0, 1'b0, 32'h0},               // R1 sel_c high
    {8'b01010110, 4'hF, 8'h13, 32'hEEEEEEEE, 1'b1, 32'h44444444}, // R6 all lanes high reads
    {8'b01010110, 4'b1101, 8'h12, 32'h0000EE00, 1'b0, 32'h0},     // R6 lane1 write
    {8'b01001111, 4'hF, 8'h12, 32'h0, 1'b1, 32'h3333EE33}         // R6
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_a_ni = 1'b1, sel_b_i = 1'b0, sel_c_ni = 1'b1;
  logic        cpu_strobe_ni = 1'b1, ctl_strobe_ni = 1'b1, adv_ni = 1'b1;
  logic [7:0]  addr_i = '0;
  logic        all_wr_ni = 1'b1, byte_qual_ni = 1'b1;
  logic [3:0]  lane_wr_ni = 4'hF;
  logic [31:0] data_i = '0;
  logic        pipe_mode_i = 1'b0, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [31:0] data_o;
  logic        data_oe_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni),
    .cpu_strobe_ni(cpu_strobe_ni), .ctl_strobe_ni(ctl_strobe_ni), .adv_ni(adv_ni), .addr_i(addr_i),
    .all_wr_ni(all_wr_ni), .byte_qual_ni(byte_qual_ni), .lane_wr_ni(lane_wr_ni), .data_i(data_i),
    .pipe_mode_i(pipe_mode_i), .oe_ni(oe_ni), .sleep_i(sleep_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic string vec_req(int i);
    case (i)
      0, 10:             return "R4";
      1, 2, 3, 7, 8, 9, 13: return "R5";
      4, 5, 18, 19, 20:  return "R6";
      6:                 return "R3";
      11, 12:            return "R2";
      15, 17:            return "R1";
      default:           return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] c, logic [3:0] bw, logic [7:0] a, logic [31:0] d);
    {sel_a_ni, sel_b_i, sel_c_ni, cpu_strobe_ni, ctl_strobe_ni, adv_ni, all_wr_ni, byte_qual_ni} = c;
    lane_wr_ni = bw;
    addr_i     = a;
    data_i     = d;
  endtask

  task automatic step(logic [7:0] c, logic [3:0] bw, logic [7:0] a, logic [31:0] d);
    drive(c, bw, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset output off", {31'b0, data_oe_o}, 32'd0);
    rst_ni = 1'b1;

    // flow-through table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][84:77], VEC[i][76:73], VEC[i][72:65], VEC[i][64:33]);
      check(vec_req(i), {31'b0, data_oe_o}, {31'b0, VEC[i][32]});
      if (VEC[i][32]) check(vec_req(i), data_o, VEC[i][31:0]);
    end

    // R8 pipeline: on two edges after select, off one edge after deselect
    pipe_mode_i = 1'b1;
    step(8'b11010111, 4'hF, 8'h0, 32'h0);
    step(8'b01001111, 4'hF, 8'h12, 32'h0);
    check("R8 pipe not yet on", {31'b0, data_oe_o}, 32'd0);
    step(8'b01011011, 4'hF, 8'h0, 32'h0);
    check("R8 pipe first word oe", {31'b0, data_oe_o}, 32'd1);
    check("R8 pipe first word", data_o, 32'h3333EE33);
    step(8'b11010111, 4'hF, 8'h0, 32'h0);
    check("R8 pipe second word", data_o, 32'h44444444);
    check("R8 pipe still on", {31'b0, data_oe_o}, 32'd1);
    step(8'b01011011, 4'hF, 8'h0, 32'h0);
    check("R8 pipe off", {31'b0, data_oe_o}, 32'd0);
    pipe_mode_i = 1'b0;

    // R9 asynchronous output enable
    step(8'b01001111, 4'hF, 8'h11, 32'h0);
    check("R9 read drives", {31'b0, data_oe_o}, 32'd1);
    oe_ni = 1'b1; #1;
    check("R9 oe high off", {31'b0, data_oe_o}, 32'd0);
    oe_ni = 1'b0; #1;
    check("R9 oe low on", {31'b0, data_oe_o}, 32'd1);

    // R10 sleep: write ignored, state held
    sleep_i = 1'b1;
    step(8'b01010101, 4'hF, 8'h11, 32'h0);
    check("R10 sleep output off", {31'b0, data_oe_o}, 32'd0);
    sleep_i = 1'b0;
    drive(8'b11111111, 4'hF, 8'h0, 32'h0);
    #1;
    check("R10 state kept oe", {31'b0, data_oe_o}, 32'd1);
    check("R10 state kept data", data_o, 32'h22222222);
    step(8'b01001111, 4'hF, 8'h11, 32'h0);
    check("R10 word kept", data_o, 32'h22222222);

    // R11 reset mid burst
    step(8'b01001111, 4'hF, 8'h10, 32'h0);
    rst_ni = 1'b0; #1;
    check("R11 reset clears output", {31'b0, data_oe_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'b01011011, 4'hF, 8'h0, 32'h0);
    check("R11 burst cleared", {31'b0, data_oe_o}, 32'd0);
    step(8'b01001111, 4'hF, 8'h11, 32'h0);
    check("R11 array kept", data_o, 32'h22222222);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule